// File: doc/BRIEF.md
# Table indirect jump sequencer

This unit carries out the execute phase of a microcontroller's table-indirect jump. Decode hands it three operands on a start pulse:

- the number of a word register that holds the base of a jump table;
- the number of a word register that holds a pointer to an index byte;
- a 7-bit immediate mask.

Over one synchronous read port it makes four reads in turn:

1. the base word;
2. the pointer word;
3. the byte the pointer addresses;
4. the 16-bit table entry, taken from the fixed top code page.

The last read uses the masked index, doubled, as the offset from the table base. The unit then presents the entry as a 24-bit program counter, with the page prefix FFh in the top byte, and pulses done.

The operation always takes the same number of cycles, whatever the operands are. This lets the surrounding pipeline count on a fixed instruction time. A typical use is an interrupt dispatch table of 21 entries: 20 source handlers and one return entry. Each entry holds only the low 16 bits of a handler address.

Top module: `tij_seq`

## Requirements
- R1: After a start accepted at clock edge E0, mem_req is high for exactly one cycle, after each of the edges E0, E2, E4 and E6, and is low in every other cycle. The four addresses are, in order:
  - {16'h0000, base_rn} for the base word;
  - {16'h0000, ptr_rn} for the pointer word;
  - {8'h00, pointer word} for the index byte;
  - {8'hFF, entry address} for the entry word.
- R2: The index is bits 6:0 of the fetched byte, ANDed with the 7-bit mask. Bit 7 of the byte and bits 15:8 of mem_rdata on a byte read have no effect.
- R3: The entry address is (base word + 2 × index) modulo 2^16, so a table that runs past FFFFh wraps to 0000h inside page FFh. Masked indices 0 to 20 each select their own entry.
- R4: When done is high, pc equals FF0000h + the entry word read at that entry address.
- R5: done is high for exactly one cycle, after the 15th clock edge following the accepting edge E0.
- R6: pc changes only on the edge that raises done, or on reset. It holds its value at all other times.
- R7: A start sampled while the unit is busy is ignored, including on the edge that raises done. A start sampled in the cycle done is high is accepted at once.
- R8: A synchronous reset returns the unit to idle. After it, done is low, mem_req is low, pc is 0, and no done follows from the aborted operation.
- R9: mem_word is 1 for the three word reads and 0 for the byte read. Read data is taken from mem_rdata in the cycle after the request, when mem_valid is high. Operands are latched at acceptance, so later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| base_rn | input | 8 | Register number of the table base word |
| ptr_rn | input | 8 | Register number of the index pointer word |
| mask | input | 7 | Immediate index mask |
| mem_req | output | 1 | Read request |
| mem_word | output | 1 | 1 = 16-bit read, 0 = byte read |
| mem_addr | output | 24 | Read address |
| mem_valid | input | 1 | Read data valid, one cycle after mem_req |
| mem_rdata | input | 16 | Read data; a byte read uses bits 7:0 |
| done | output | 1 | One-cycle completion strobe |
| pc | output | 24 | New program counter |

## Verification
Every result is counted in clock edges from the edge that accepts start. The four requests are due in the cycles after edges 0, 2, 4 and 6. Read data returns one edge later. done and the new pc are due after edge 15, and a start in the done cycle restarts the count from that edge.

A behavioural model in the bench keeps this edge count itself. It predicts mem_req, mem_addr, mem_word, done and pc for every cycle, and the bench compares them at the falling edge. The directed tests also count falling edges from start to done to confirm the fixed latency. They check the final pc against values worked out with modulo arithmetic rather than bit slicing.

// File: rtl/tij_pkg.sv
package tij_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 7;
  localparam int PAGE_W = 8;
  localparam int ADDR_W = PAGE_W + WORD_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RQ_BASE, ST_WT_BASE,
    ST_RQ_PTR,  ST_WT_PTR,
    ST_RQ_IDX,  ST_WT_IDX,
    ST_RQ_ENT,  ST_WT_ENT,
    ST_PAD
  } tij_state_e;

  typedef enum logic [1:0] {
    RD_BASE, RD_PTR, RD_IDX, RD_ENT
  } tij_rd_e;

  // keep the low index bits of the fetched byte and apply the immediate mask
  function automatic logic [IDX_W-1:0] idx_sel(logic [BYTE_W-1:0] raw,
                                               logic [IDX_W-1:0]  msk);
    return raw[IDX_W-1:0] & msk;
  endfunction

  // table base plus doubled index, truncated to the word width
  function automatic logic [WORD_W-1:0] entry_addr(logic [WORD_W-1:0] base,
                                                   logic [IDX_W-1:0]  idx);
    logic [WORD_W-1:0] off;
    off = WORD_W'({idx, 1'b0});
    return base + off;
  endfunction

  // place a 16-bit target into the fixed page
  function automatic logic [ADDR_W-1:0] far_pc(logic [PAGE_W-1:0] page,
                                               logic [WORD_W-1:0] tgt);
    return {page, tgt};
  endfunction

endpackage

// File: rtl/tij_timer.sv
module tij_timer #(
  parameter int LAT = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic busy,
  output logic at_end
);
  localparam int CW = $clog2(LAT);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (accept) begin
      cnt <= '0;
    end else if (busy && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_end = busy && (cnt == LAST);
endmodule

// File: rtl/tij_fsm.sv
module tij_fsm
  import tij_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    mem_valid,
  input  logic    at_end,
  output logic    accept,
  output logic    busy,
  output logic    mem_req,
  output logic    cap,
  output tij_rd_e rd_sel,
  output logic    finish,
  output logic    done
);
  tij_state_e state, nxt;
  logic       waiting;

  assign busy    = (state != ST_IDLE);
  assign accept  = (state == ST_IDLE) && start;
  assign finish  = (state == ST_PAD) && at_end;
  assign mem_req = (state == ST_RQ_BASE) || (state == ST_RQ_PTR) ||
                   (state == ST_RQ_IDX)  || (state == ST_RQ_ENT);
  assign waiting = (state == ST_WT_BASE) || (state == ST_WT_PTR) ||
                   (state == ST_WT_IDX)  || (state == ST_WT_ENT);
  assign cap     = waiting && mem_valid;

  always_comb begin
    case (state)
      ST_RQ_PTR, ST_WT_PTR: rd_sel = RD_PTR;
      ST_RQ_IDX, ST_WT_IDX: rd_sel = RD_IDX;
      ST_RQ_ENT, ST_WT_ENT: rd_sel = RD_ENT;
      default:              rd_sel = RD_BASE;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:    if (start) nxt = ST_RQ_BASE;
      ST_RQ_BASE: nxt = ST_WT_BASE;
      ST_WT_BASE: if (mem_valid) nxt = ST_RQ_PTR;
      ST_RQ_PTR:  nxt = ST_WT_PTR;
      ST_WT_PTR:  if (mem_valid) nxt = ST_RQ_IDX;
      ST_RQ_IDX:  nxt = ST_WT_IDX;
      ST_WT_IDX:  if (mem_valid) nxt = ST_RQ_ENT;
      ST_RQ_ENT:  nxt = ST_WT_ENT;
      ST_WT_ENT:  if (mem_valid) nxt = ST_PAD;
      ST_PAD:     if (at_end) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
    end
  end
endmodule

// File: rtl/tij_dp.sv
module tij_dp
  import tij_pkg::*;
#(
  parameter int                RNUM_W = 8,
  parameter logic [PAGE_W-1:0] PAGE   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              cap,
  input  logic              finish,
  input  logic              mem_req,
  input  tij_rd_e           rd_sel,
  input  logic [RNUM_W-1:0] base_rn,
  input  logic [RNUM_W-1:0] ptr_rn,
  input  logic [IDX_W-1:0]  mask_i,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_word,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] ent_addr
);
  logic [RNUM_W-1:0] rn_b, rn_p;
  logic [IDX_W-1:0]  msk;
  logic [WORD_W-1:0] base_q, ptr_q, tgt_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rn_b <= '0;
      rn_p <= '0;
      msk  <= '0;
    end else if (accept) begin
      rn_b <= base_rn;
      rn_p <= ptr_rn;
      msk  <= mask_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ptr_q  <= '0;
      idx_q  <= '0;
      tgt_q  <= '0;
    end else if (cap) begin
      case (rd_sel)
        RD_BASE: base_q <= rdata;
        RD_PTR:  ptr_q  <= rdata;
        RD_IDX:  idx_q  <= idx_sel(rdata[BYTE_W-1:0], msk);
        default: tgt_q  <= rdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (finish) begin
      pc <= far_pc(PAGE, tgt_q);
    end
  end

  assign ent_addr = entry_addr(base_q, idx_q);

  always_comb begin
    mem_addr = '0;
    if (mem_req) begin
      case (rd_sel)
        RD_BASE: mem_addr = ADDR_W'(rn_b);
        RD_PTR:  mem_addr = ADDR_W'(rn_p);
        RD_IDX:  mem_addr = ADDR_W'(ptr_q);
        default: mem_addr = far_pc(PAGE, ent_addr);
      endcase
    end
  end

  assign mem_word = mem_req && (rd_sel != RD_IDX);
endmodule

// File: rtl/tij_seq.sv
module tij_seq
  import tij_pkg::*;
#(
  parameter int                LAT    = 15,
  parameter int                RNUM_W = 8,
  parameter logic [PAGE_W-1:0] PAGE   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RNUM_W-1:0] base_rn,
  input  logic [RNUM_W-1:0] ptr_rn,
  input  logic [IDX_W-1:0]  mask,
  output logic              mem_req,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] pc
);
  logic              accept, busy, cap, finish, at_end;
  tij_rd_e           rd_sel;
  logic [WORD_W-1:0] ent_addr;

  tij_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .mem_valid(mem_valid),
    .at_end(at_end), .accept(accept), .busy(busy), .mem_req(mem_req),
    .cap(cap), .rd_sel(rd_sel), .finish(finish), .done(done)
  );

  tij_timer #(.LAT(LAT)) u_timer (
    .clk(clk), .rst(rst), .accept(accept), .busy(busy), .at_end(at_end)
  );

  tij_dp #(.RNUM_W(RNUM_W), .PAGE(PAGE)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .cap(cap), .finish(finish),
    .mem_req(mem_req), .rd_sel(rd_sel), .base_rn(base_rn), .ptr_rn(ptr_rn),
    .mask_i(mask), .rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_word(mem_word), .pc(pc), .ent_addr(ent_addr)
  );
endmodule

// File: rtl/tij_chk.sv
module tij_chk
  import tij_pkg::*;
#(
  parameter logic [PAGE_W-1:0] PAGE = 8'hFF
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_word,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [ADDR_W-1:0] pc
);
  logic [4:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
    end else if (accept) begin
      age <= 5'd1;
    end else if (age != 5'd0 && age != 5'd31) begin
      age <= age + 5'd1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> age == 5'd16); // R5
  AST_PC_PAGE: assert property (@(posedge clk) disable iff (rst) done |-> pc[ADDR_W-1:WORD_W] == PAGE); // R4
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(pc) |-> (done || $past(rst))); // R6
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst) mem_req |-> busy); // R1
  AST_REQ_SPACED: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R1
  AST_ENT_PAGE: assert property (@(posedge clk) disable iff (rst) (mem_req && age == 5'd7) |-> (mem_word && mem_addr[ADDR_W-1:WORD_W] == PAGE)); // R9
  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst) accept |-> (age == 5'd0 || age >= 5'd16)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (!done && !mem_req)); // R8
endmodule

bind tij_seq tij_chk #(.PAGE(PAGE)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .busy(busy), .mem_req(mem_req),
  .mem_word(mem_word), .mem_addr(mem_addr), .done(done), .pc(pc)
);

// File: tb/tij_seq_tb_top.sv
module tij_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  base_rn = '0, ptr_rn = '0;
  logic [6:0]  mask = '0;
  logic        mem_req, mem_word, mem_valid = 1'b0, done;
  logic [23:0] mem_addr, pc;
  logic [15:0] mem_rdata = '0;

  int checks = 0, errors = 0, ndone = 0;
  bit finished = 0, armed = 0;

  always #10 clk = ~clk;

  tij_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .base_rn(base_rn), .ptr_rn(ptr_rn),
    .mask(mask), .mem_req(mem_req), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .pc(pc)
  );

  logic [15:0] wmem [int];
  logic [7:0]  bmem [int];

  function automatic logic [15:0] rdw(int a);
    if (wmem.exists(a)) return wmem[a];
    return 16'((a * 40503) ^ 16'h3c5a);
  endfunction

  function automatic logic [7:0] rdb(int a);
    if (bmem.exists(a)) return bmem[a];
    return 8'((a * 77) ^ 8'h96);
  endfunction

  always @(posedge clk) begin
    mem_valid <= mem_req;
    mem_rdata <= mem_word ? rdw(int'(mem_addr)) : {8'hE7, rdb(int'(mem_addr))};
  end

  // behavioural reference: edge count since acceptance
  int          age = -1;
  int          ex_addr [4];
  bit          ex_word [4];
  logic [23:0] pc_exp = '0, pc_nxt = '0;

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      age = -1;
      pc_exp = '0;
    end else if ((age < 0 || age == 15) && start) begin
      int b, p, ix, e;
      b  = int'(rdw(int'(base_rn)));
      p  = int'(rdw(int'(ptr_rn)));
      ix = (int'(rdb(p)) % 128) & int'(mask);
      e  = (b + ix + ix) % 65536;
      ex_addr[0] = int'(base_rn); ex_word[0] = 1;
      ex_addr[1] = int'(ptr_rn);  ex_word[1] = 1;
      ex_addr[2] = p;             ex_word[2] = 0;
      ex_addr[3] = 16711680 + e;  ex_word[3] = 1;
      pc_nxt = 24'(16711680 + int'(rdw(16711680 + e)));
      age = 0;
    end else if (age >= 15) begin
      age = -1;
    end else if (age >= 0) begin
      age = age + 1;
      if (age == 15) pc_exp = pc_nxt;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !finished) begin
      bit rq;
      rq = (age == 0 || age == 2 || age == 4 || age == 6);
      chk(mem_req == rq, "R1 mem_req", 32'(mem_req), 32'(rq));
      if (rq) begin
        chk(int'(mem_addr) == ex_addr[age/2], "R1 mem_addr", 32'(mem_addr), 32'(ex_addr[age/2]));
        chk(mem_word == ex_word[age/2], "R9 mem_word", 32'(mem_word), 32'(ex_word[age/2]));
      end
      chk(done == (age == 15), "R5 done", 32'(done), 32'(age == 15));
      chk(pc == pc_exp, "R6 pc", 32'(pc), 32'(pc_exp));
      if (done) ndone++;
    end
  end

  // one operation; returns edges from acceptance to done
  task automatic run_op(input logic [7:0] rb, input logic [7:0] rp, input logic [6:0] m,
                        input bit pester, output int lat);
    @(negedge clk);
    base_rn = rb; ptr_rn = rp; mask = m; start = 1;
    @(negedge clk);
    start = 0; base_rn = ~rb; ptr_rn = ~rp; mask = ~m;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (pester) start = (lat % 3 == 1);
    end
    start = 0;
  endtask

  task automatic setup(input logic [7:0] rb, input logic [7:0] rp, input logic [15:0] base,
                       input logic [15:0] ptr, input logic [7:0] raw, input int ent,
                       input logic [15:0] tgt);
    wmem[int'(rb)] = base;
    wmem[int'(rp)] = ptr;
    bmem[int'(ptr)] = raw;
    wmem[16711680 + ent] = tgt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, nd0;
    logic [23:0] keep;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(done == 0 && mem_req == 0 && pc == 0, "R8 reset state", {done, mem_req, pc}, 0);

    // 21-entry dispatch table, indices 0..20
    for (int i = 0; i <= 20; i++) begin
      setup(8'h20, 8'h22, 16'h1200, 16'h0040, 8'(i), 16'h1200 + 2 * i, 16'(16'h4000 + i * 16'h111));
      run_op(8'h20, 8'h22, 7'h7F, 0, lat);
      chk(lat == 15, "R5 latency", lat, 15);
      chk(pc == 24'(16711680 + 16384 + i * 273), "R3 table entry", pc, 24'(16711680 + 16384 + i * 273));
      chk(pc[23:16] == 8'hFF, "R4 page prefix", pc[23:16], 8'hFF);
    end

    // bit 7 of the index byte ignored
    setup(8'h30, 8'h32, 16'h2000, 16'h0051, 8'h85, 16'h200A, 16'hBEEF);
    run_op(8'h30, 8'h32, 7'h7F, 0, lat);
    chk(pc == 24'hFFBEEF, "R2 bit7 ignored", pc, 24'hFFBEEF);

    // mask narrows the index
    setup(8'h34, 8'h36, 16'h3000, 16'h0062, 8'h3F, 16'h3018, 16'h1357);
    run_op(8'h34, 8'h36, 7'h0C, 0, lat);
    chk(pc == 24'hFF1357, "R2 mask applied", pc, 24'hFF1357);

    // zero mask selects entry 0
    setup(8'h38, 8'h3A, 16'h3400, 16'h0063, 8'h7F, 16'h3400, 16'h2468);
    run_op(8'h38, 8'h3A, 7'h00, 0, lat);
    chk(pc == 24'hFF2468, "R2 zero mask", pc, 24'hFF2468);

    // wrap of base + offset inside the page
    setup(8'h40, 8'h42, 16'hFFF8, 16'h0070, 8'h0A, 16'h000C, 16'hCAFE);
    run_op(8'h40, 8'h42, 7'h7F, 0, lat);
    chk(pc == 24'hFFCAFE, "R3 wraparound", pc, 24'hFFCAFE);

    // pc holds after done
    keep = pc;
    repeat (10) @(negedge clk);
    chk(pc == keep, "R6 pc hold", pc, keep);

    // start while busy ignored
    setup(8'h44, 8'h46, 16'h5000, 16'h0080, 8'h03, 16'h5006, 16'h0F0F);
    nd0 = ndone;
    run_op(8'h44, 8'h46, 7'h7F, 1, lat);
    repeat (20) @(negedge clk);
    chk(lat == 15, "R7 latency under pester", lat, 15);
    chk(ndone - nd0 == 1, "R7 one done", ndone - nd0, 1);
    chk(pc == 24'hFF0F0F, "R7 result", pc, 24'hFF0F0F);

    // start held high: back-to-back operations, restart in done cycle
    nd0 = ndone;
    @(negedge clk);
    base_rn = 8'h44; ptr_rn = 8'h46; mask = 7'h7F; start = 1;
    repeat (40) @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    chk(ndone - nd0 == 3, "R7 back-to-back", ndone - nd0, 3);

    // reset during an operation
    nd0 = ndone;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(done == 0 && mem_req == 0 && pc == 0, "R8 mid-op reset", {done, mem_req, pc}, 0);
    repeat (20) @(negedge clk);
    chk(ndone == nd0, "R8 no done after reset", ndone - nd0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule